// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns characters held in a small transmit queue into asynchronous serial frames on a single output line. Software-visible settings arrive as two packed words. A mode word picks the character width (6, 7 or 8 bits), one of five parity options (even, odd, forced zero, forced one, or none) and one or two stop bits. Command strobes written through a control word turn the transmitter on or off, flush the queue and the frame engine, and begin or end a break, during which the line is held low.

Bit timing comes from outside: a baud generator supplies `bit_tick`, a pulse one clock cycle wide, once per bit period. Every bit of a frame lasts exactly one tick period. A new frame starts only on a tick. A character waiting in the queue is chained straight onto the previous frame with no idle bit between them. The queue-empty and queue-full flags, and a combined transmit-empty flag, go to a separate status and interrupt block.

The frame engine is a five-state machine. IDLE holds the line high. START sends the 0 start bit. DATA sends the character, least significant bit first. PARITY sends the parity bit. STOP sends the 1 stop bits. On each tick the transitions are as follows. IDLE→START happens when the transmitter is on, no break is active and the queue holds a character. START→DATA is unconditional. DATA→DATA repeats until the last data bit. DATA→PARITY follows when parity is selected, and DATA→STOP when it is not. PARITY→STOP is unconditional. STOP→STOP covers the second stop bit. STOP→START chains the next character. STOP→IDLE happens when nothing can follow. A queue flush forces any state to IDLE at once.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is 1, the queue-empty flag is 1, the queue-full flag is 0, transmit-empty is 1 and the transmitter is off.
- R2: A frame consists of a 0 start bit, then the data bits least significant bit first, then the optional parity bit, then stop bits at 1. Each bit lasts one tick period, and the idle line is 1.
- R3: `mode_cfg[2:1]` selects the character width: 00 selects 8 bits, 10 selects 7 and 11 selects 6. Data bits above the selected width are not sent.
- R4: `mode_cfg[5:3]` selects parity. 000 makes the total count of ones even and 001 makes it odd. 010 sends a constant 0 and 011 a constant 1. Any value 1xx sends no parity bit.
- R5: `mode_cfg[7:6]` set to 00 gives one stop bit and 10 gives two. Back-to-back frames start exactly one frame length apart.
- R6: The queue holds 16 characters. A `data_wr` pulse pushes `data_in`. The full flag is set when 16 characters are held, and a push while full is dropped.
- R7: In a `ctrl_wr` pulse, `ctrl_data[4]` turns the transmitter on and `ctrl_data[5]` turns it off; when both are set the transmitter ends up off. While off, no frame starts and queued characters stay queued.
- R8: A frame starts only on a cycle where `bit_tick` is 1, the transmitter is on and the queue is not empty.
- R9: `ctrl_data[1]` in a `ctrl_wr` pulse flushes the queue and the frame engine within two cycles. Flushed characters are never sent.
- R10: `ctrl_data[7]` begins a break and the line is 0 from the next cycle for as long as the break lasts. `ctrl_data[8]` ends it; when both are set the break ends.
- R11: Transmit-empty is 1 only when the queue is empty and the last frame has finished its final stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| mode_cfg | input | 8 | Packed frame settings: width [2:1], parity [5:3], stop bits [7:6] |
| ctrl_wr | input | 1 | Strobe for the command bits in ctrl_data |
| ctrl_data | input | 9 | Command bits: flush [1], on [4], off [5], break begin [7], break end [8] |
| data_wr | input | 1 | Push strobe for the transmit queue |
| data_in | input | 8 | Character to push |
| tx_line | output | 1 | Serial output line |
| fifo_empty | output | 1 | Queue holds no character |
| fifo_full | output | 1 | Queue holds 16 characters |
| tx_empty | output | 1 | Queue empty and the frame engine is idle |

## Verification
A bit counter or width decode that is off shows up within a single frame: the line carries the wrong bit in a data, parity or stop slot, and the next start bit falls at the wrong distance from the previous one. A state machine stuck outside IDLE keeps transmit-empty low, so this is visible after one frame time. Queue pointer or count faults show as swapped, repeated or missing characters, or as a wrong full flag at the 16th push. These appear as soon as the queue is filled or drained.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MODE_W = 8;
    localparam int CTRL_W = 9;
    localparam int CNT_W  = 4;

    // command bit positions in the control word
    localparam int CB_RST     = 1;
    localparam int CB_EN      = 4;
    localparam int CB_DIS     = 5;
    localparam int CB_BRK_ON  = 7;
    localparam int CB_BRK_OFF = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] nbits;
        logic             par_en;
        logic             par_fixed;
        logic             par_sel;
        logic             two_stop;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:1] m);
        frame_cfg_t c;
        case (m[2:1])
            2'b10:   c.nbits = CNT_W'(7);
            2'b11:   c.nbits = CNT_W'(6);
            default: c.nbits = CNT_W'(8);
        endcase
        c.par_en    = ~m[5];
        c.par_fixed = m[4];
        c.par_sel   = m[3];
        c.two_stop  = m[7] | m[6];
        return c;
    endfunction
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_TOP = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_TOP) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_TOP) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    output logic              tx_en,
    output logic              brk_on,
    output logic              soft_rst
);
    timeunit 1ns;
    timeprecision 100ps;

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{ctrl_data[6], ctrl_data[3:2], ctrl_data[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            brk_on   <= 1'b0;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= ctrl_wr && ctrl_data[CB_RST];
            if (ctrl_wr) begin
                if (ctrl_data[CB_DIS])      tx_en <= 1'b0;
                else if (ctrl_data[CB_EN])  tx_en <= 1'b1;
                if (ctrl_data[CB_BRK_OFF])     brk_on <= 1'b0;
                else if (ctrl_data[CB_BRK_ON]) brk_on <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         bit_tick,
    input  logic         tx_en,
    input  logic         brk_on,
    input  frame_cfg_t   cfg,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_dout,
    output logic         fifo_pop,
    output logic         line,
    output logic         busy
);
    timeunit 1ns;
    timeprecision 100ps;

    tx_state_e        state;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bit_cnt;
    frame_cfg_t       cfg_q;
    logic             par_acc;
    logic             stop_left;
    logic             start_ok;
    logic             par_bit;
    logic             line_raw;

    assign start_ok = tx_en && !brk_on && !fifo_empty;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bit_cnt   <= '0;
            cfg_q     <= '0;
            par_acc   <= 1'b0;
            stop_left <= 1'b0;
        end else if (flush) begin
            state     <= ST_IDLE;
            stop_left <= 1'b0;
        end else if (bit_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state   <= ST_START;
                        shreg   <= fifo_dout;
                        cfg_q   <= cfg;
                        par_acc <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
                ST_START: begin
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    par_acc <= par_acc ^ shreg[0];
                    if (bit_cnt == cfg_q.nbits - 1'b1) begin
                        if (cfg_q.par_en) begin
                            state <= ST_PARITY;
                        end else begin
                            state     <= ST_STOP;
                            stop_left <= cfg_q.two_stop;
                        end
                    end else begin
                        shreg   <= {1'b0, shreg[W-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    state     <= ST_STOP;
                    stop_left <= cfg_q.two_stop;
                end
                ST_STOP: begin
                    if (stop_left) begin
                        stop_left <= 1'b0;
                    end else if (start_ok) begin
                        state   <= ST_START;
                        shreg   <= fifo_dout;
                        cfg_q   <= cfg;
                        par_acc <= 1'b0;
                        bit_cnt <= '0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        par_bit  = cfg_q.par_fixed ? cfg_q.par_sel : (par_acc ^ cfg_q.par_sel);
        fifo_pop = 1'b0;
        line_raw = 1'b1;
        unique case (state)
            ST_IDLE: begin
                line_raw = 1'b1;
                fifo_pop = bit_tick && start_ok && !flush;
            end
            ST_START:  line_raw = 1'b0;
            ST_DATA:   line_raw = shreg[0];
            ST_PARITY: line_raw = par_bit;
            ST_STOP: begin
                line_raw = 1'b1;
                fifo_pop = bit_tick && start_ok && !stop_left && !flush;
            end
            default:   line_raw = 1'b1;
        endcase
        line = brk_on ? 1'b0 : line_raw;
        busy = (state != ST_IDLE);
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [MODE_W-1:0] mode_cfg,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic              tx_line,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              tx_empty
);
    timeunit 1ns;
    timeprecision 100ps;

    logic              tx_en;
    logic              brk_on;
    logic              soft_rst;
    logic              fifo_pop;
    logic [DATA_W-1:0] fifo_dout;
    logic              busy;
    frame_cfg_t        cfg;
    logic              unused_mode_bit;

    assign unused_mode_bit = mode_cfg[0];
    assign cfg             = decode_mode(mode_cfg[MODE_W-1:1]);
    assign tx_empty        = fifo_empty && !busy;

    tx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (ctrl_data),
        .tx_en     (tx_en),
        .brk_on    (brk_on),
        .soft_rst  (soft_rst)
    );

    tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst),
        .push  (data_wr),
        .din   (data_in),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    tx_shifter #(.W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (soft_rst),
        .bit_tick   (bit_tick),
        .tx_en      (tx_en),
        .brk_on     (brk_on),
        .cfg        (cfg),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .fifo_pop   (fifo_pop),
        .line       (tx_line),
        .busy       (busy)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic ctrl_wr,
    input logic brk_start,
    input logic rst_cmd,
    input logic tx_line,
    input logic fifo_empty,
    input logic fifo_full,
    input logic tx_empty,
    input logic tx_en,
    input logic brk_on
);
    timeunit 1ns;
    timeprecision 100ps;

    // R10
    brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> !tx_line);

    // R6
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

    // R8
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_on && $fell(tx_line)) |-> $past(bit_tick));

    // R11
    txe_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> fifo_empty);

    // R9
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_cmd, 2) |-> fifo_empty);

    // R7
    off_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && tx_empty && !brk_on && !ctrl_wr) |=> tx_line);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .ctrl_wr    (ctrl_wr),
    .brk_start  (ctrl_wr && ctrl_data[uart_tx_pkg::CB_BRK_ON] && !ctrl_data[uart_tx_pkg::CB_BRK_OFF]),
    .rst_cmd    (ctrl_wr && ctrl_data[uart_tx_pkg::CB_RST]),
    .tx_line    (tx_line),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .tx_empty   (tx_empty),
    .tx_en      (tx_en),
    .brk_on     (brk_on)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int TICK = 8;

    typedef struct {
        logic [7:0] data;
        int         nbits;
        logic [2:0] par;
        bit         two;
        bit         b2b;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [7:0] mode_cfg = 8'h20;
    logic       ctrl_wr = 1'b0;
    logic [8:0] ctrl_data = '0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic       tx_line, fifo_empty, fifo_full, tx_empty;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   last_tick_cyc = -1;
    int   last_start = 0;
    int   last_bits = 0;
    bit   mon_en = 1'b0;
    bit   mon_busy = 1'b0;
    int   cur_len = 8;
    logic [2:0] cur_par = 3'b100;
    bit   cur_two = 1'b0;
    exp_t q[$];

    uart_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode_cfg(mode_cfg),
        .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .data_wr(data_wr),
        .data_in(data_in), .tx_line(tx_line), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .tx_empty(tx_empty)
    );

    always #2.5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial forever begin
        repeat (TICK - 1) @(negedge clk);
        bit_tick = 1'b1;
        last_tick_cyc = cyc + 1;
        @(negedge clk);
        bit_tick = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input int n, input logic [2:0] p);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += int'(d[i]);
        case (p)
            3'b000:  return logic'(ones % 2);
            3'b001:  return logic'((ones + 1) % 2);
            3'b010:  return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic set_mode(input int len, input logic [2:0] par, input bit two);
        logic [1:0] lb;
        lb = (len == 8) ? 2'b00 : (len == 7) ? 2'b10 : 2'b11;
        @(negedge clk);
        mode_cfg = {two, 1'b0, par, lb, 1'b0};
        cur_len = len;
        cur_par = par;
        cur_two = two;
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        @(negedge clk);
        ctrl_data = v;
        ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        ctrl_data = '0;
    endtask

    task automatic push_raw(input logic [7:0] d);
        @(negedge clk);
        data_in = d;
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input bit b2b);
        exp_t e;
        e.data = d;
        e.nbits = cur_len;
        e.par = cur_par;
        e.two = cur_two;
        e.b2b = b2b;
        q.push_back(e);
        push_raw(d);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0 || mon_busy || !tx_empty) @(negedge clk);
        repeat (16) @(negedge clk);
    endtask

    // monitor: decodes frames on the line and compares with the scoreboard
    initial forever begin
        @(negedge clk);
        if (mon_en && tx_line == 1'b0) begin
            int start_cyc;
            exp_t e;
            logic [7:0] got;
            logic [7:0] want;
            mon_busy = 1'b1;
            start_cyc = cyc;
            chk(start_cyc == last_tick_cyc, "R8 start aligned to tick", start_cyc, last_tick_cyc);
            if (q.size() == 0) begin
                chk(1'b0, "R7 unexpected frame", 1, 0);
                repeat (TICK * 12) @(negedge clk);
            end else begin
                e = q.pop_front();
                if (e.b2b)
                    chk(start_cyc - last_start == TICK * last_bits, "R5 frame spacing",
                        start_cyc - last_start, TICK * last_bits);
                repeat (TICK / 2 - 1) @(negedge clk);
                chk(tx_line == 1'b0, "R2 start bit", int'(tx_line), 0);
                got = '0;
                for (int i = 0; i < e.nbits; i++) begin
                    repeat (TICK) @(negedge clk);
                    got[i] = tx_line;
                end
                want = e.data & 8'((1 << e.nbits) - 1);
                chk(got == want, "R3 data bits", int'(got), int'(want));
                if (!e.par[2]) begin
                    logic pb;
                    pb = exp_parity(e.data, e.nbits, e.par);
                    repeat (TICK) @(negedge clk);
                    chk(tx_line == pb, "R4 parity bit", int'(tx_line), int'(pb));
                end
                for (int s = 0; s < (e.two ? 2 : 1); s++) begin
                    repeat (TICK) @(negedge clk);
                    chk(tx_line == 1'b1, "R2 stop bit", int'(tx_line), 1);
                end
                last_start = start_cyc;
                last_bits = 1 + e.nbits + (e.par[2] ? 0 : 1) + (e.two ? 2 : 1);
            end
            mon_busy = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1 line idle", int'(tx_line), 1);
        chk(fifo_empty == 1'b1, "R1 fifo_empty", int'(fifo_empty), 1);
        chk(fifo_full == 1'b0, "R1 fifo_full", int'(fifo_full), 0);
        chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        // R7 off after reset: pushed char stays queued
        push_raw(8'h11);
        repeat (40) @(negedge clk);
        chk(fifo_empty == 1'b0, "R1 off after reset", int'(fifo_empty), 0);
        wr_ctrl(9'h002);
        repeat (2) @(negedge clk);
        mon_en = 1'b1;

        // 8 bits, no parity, one stop
        set_mode(8, 3'b100, 1'b0);
        wr_ctrl(9'h010);
        send(8'hA5, 1'b0);
        repeat (20) @(negedge clk);
        chk(tx_empty == 1'b0, "R11 busy while sending", int'(tx_empty), 0);
        wait_idle();
        chk(tx_empty == 1'b1, "R11 empty after last frame", int'(tx_empty), 1);

        // 7 bits, even parity, one stop
        set_mode(7, 3'b000, 1'b0);
        send(8'h3C, 1'b0);
        send(8'hFF, 1'b1);
        send(8'h01, 1'b1);
        wait_idle();

        // 6 bits, odd parity, two stops
        set_mode(6, 3'b001, 1'b1);
        send(8'h2A, 1'b0);
        send(8'hC0, 1'b1);
        send(8'h15, 1'b1);
        wait_idle();

        // 8 bits, forced zero, then forced one, then none with two stops
        set_mode(8, 3'b010, 1'b0);
        send(8'hFF, 1'b0);
        send(8'h81, 1'b1);
        wait_idle();
        set_mode(8, 3'b011, 1'b0);
        send(8'h00, 1'b0);
        send(8'h7E, 1'b1);
        wait_idle();
        set_mode(8, 3'b100, 1'b1);
        send(8'h5A, 1'b0);
        send(8'hC3, 1'b1);
        wait_idle();

        // R6 fill queue while off, overflow push dropped
        set_mode(8, 3'b000, 1'b0);
        wr_ctrl(9'h020);
        for (int i = 0; i < 16; i++) begin
            send(8'(i * 17 + 3), i != 0);
            if (i == 14)
                chk(fifo_full == 1'b0, "R6 not full at 15", int'(fifo_full), 0);
        end
        chk(fifo_full == 1'b1, "R6 full at 16", int'(fifo_full), 1);
        push_raw(8'hEE);
        chk(fifo_full == 1'b1, "R6 still full", int'(fifo_full), 1);
        repeat (40) @(negedge clk);
        chk(q.size() == 16, "R7 nothing sent while off", q.size(), 16);
        wr_ctrl(9'h010);
        wait_idle();
        chk(fifo_empty == 1'b1, "R6 drained", int'(fifo_empty), 1);

        // R7 enable and disable together: disable wins
        wr_ctrl(9'h030);
        push_raw(8'h42);
        push_raw(8'h24);
        repeat (60) @(negedge clk);
        chk(fifo_empty == 1'b0, "R7 disable wins", int'(fifo_empty), 0);
        // R9 flush discards queued characters
        wr_ctrl(9'h002);
        @(negedge clk);
        chk(fifo_empty == 1'b1, "R9 flushed", int'(fifo_empty), 1);
        wr_ctrl(9'h010);
        repeat (100) @(negedge clk);
        chk(tx_empty == 1'b1, "R9 nothing after flush", int'(tx_empty), 1);

        // R10 break
        mon_en = 1'b0;
        wr_ctrl(9'h080);
        chk(tx_line == 1'b0, "R10 break low", int'(tx_line), 0);
        for (int k = 0; k < 4; k++) begin
            repeat (TICK) @(negedge clk);
            chk(tx_line == 1'b0, "R10 break held", int'(tx_line), 0);
        end
        wr_ctrl(9'h180);
        chk(tx_line == 1'b1, "R10 break ended", int'(tx_line), 1);
        repeat (4) @(negedge clk);
        mon_en = 1'b1;
        send(8'h69, 1'b0);
        wait_idle();
        chk(q.size() == 0, "R2 frame after break", q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule